// File: doc/BRIEF.md
# Generated-Clock Lock Qualifier

This block decides whether a synthesized clock has settled close to its intended frequency and reports that decision as a LOCK status bit. It counts rising edges of the generated clock over a gate of a fixed number of reference-clock cycles. It checks each count against the product of the active multiplier setting and the gate length, using a percentage tolerance band. A single good count is not enough to raise LOCK. The frequency must stay inside the band for a run of consecutive gates. At the shipped defaults that run lasts about 20 ms, while the loop itself normally reaches accuracy within about 2 ms.

The generated-clock edge count is held in a Gray-coded free-running counter, and the reference domain samples that counter through a two-stage synchronizer. The block also keeps a sticky loss flag. The flag records every drop of LOCK that follows a first successful lock, and software clears it by writing a one. An optional interrupt output mirrors the loss flag.

At the defaults, the multiplier setting is 11 bits wide, so the nominal setting of 1280 fits. The gate is 4 reference cycles, so the expected count is 5120. The band is ±6%, and qualification takes 160 gates.

Top module: `fll_lock_detect`

## Requirements
- R1: Each measurement counts generated-clock rising edges across GATE_CYC reference cycles. The count is in tolerance when it lies within ±TOL_PCT percent of mult_cfg × GATE_CYC, so counts 4.8% low or 4.2% high keep LOCK asserted.
- R2: A measurement outside the band clears LOCK at the end of that gate and restarts qualification. Counts 8.7% high and 11% low are both outside the band.
- R3: LOCK rises only after QUAL_GATES consecutive in-tolerance measurements. The first gate after reset, and the first gate after a configuration change, are discarded.
- R4: loss_flag becomes 1 in the cycle in which LOCK falls from 1 to 0. It never sets before the first lock.
- R5: A write (wr_en=1) with wr_data=1 clears loss_flag. A write with wr_data=0 leaves it unchanged.
- R6: When a clear write and a LOCK drop happen in the same cycle, loss_flag ends up set.
- R7: Any change of mult_cfg clears LOCK on the next reference clock edge and restarts qualification under the new value.
- R8: With IRQ_EN=1, irq is 1 exactly while loss_flag is 1.
- R9: During and directly after synchronous reset, lock, loss_flag and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock. It times the gates and all status logic. |
| gen_clk | input | 1 | Generated clock under observation. |
| rst | input | 1 | Synchronous active-high reset in the ref_clk domain. |
| mult_cfg | input | MULT_W | Multiplier setting that sets the expected count per gate. |
| wr_en | input | 1 | Status write strobe (ref_clk domain). |
| wr_data | input | 1 | Write data. A value of 1 clears the loss flag. |
| lock | output | 1 | Qualified lock status. |
| loss_flag | output | 1 | Sticky record of a lost lock. |
| irq | output | 1 | Interrupt request that follows loss_flag when IRQ_EN=1. |

## Verification
The bench builds the block with GATE_CYC=40, QUAL_GATES=8, CNT_W=10 and multipliers of 3 and 4, and it drives a 250 MHz reference clock. With these values one gate takes 160 ns and one qualification window about 1.3 µs. The bench can therefore cover a full lock, a loss, a restart and a relock in a few thousand cycles. The expected counts are 120 and 160 edges, so a generated-clock period with picosecond resolution can place a measurement just inside or clearly outside the 6% band on either side.

// File: rtl/fll_lock_pkg.sv
`timescale 1ns/1ps
package fll_lock_pkg;
  localparam int PCT_SCALE = 100;
  localparam int SYNC_STAGES = 2;

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/fll_gen_counter.sv
`timescale 1ns/1ps
module fll_gen_counter import fll_lock_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             gen_clk,
  input  logic             rst,
  output logic [CNT_W-1:0] gray_cnt
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic [CNT_W-1:0]       bin_cnt;
  logic [CNT_W-1:0]       bin_inc;
  logic [31:0]            gray_wide;

  // reset carried into the generated-clock domain
  always_ff @(posedge gen_clk) rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], rst};

  assign bin_inc   = bin_cnt + 1'b1;
  assign gray_wide = bin_to_gray(32'(bin_inc));

  always_ff @(posedge gen_clk) begin
    if (rst_pipe[SYNC_STAGES-1]) begin
      bin_cnt  <= '0;
      gray_cnt <= '0;
    end else begin
      bin_cnt  <= bin_inc;
      gray_cnt <= gray_wide[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/fll_cnt_sync.sv
`timescale 1ns/1ps
module fll_cnt_sync import fll_lock_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] bin_out
);
  logic [CNT_W-1:0] stage [SYNC_STAGES];
  logic [31:0]      bin_wide;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else if (s == 0) stage[s] <= gray_in;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign bin_wide = gray_to_bin(32'(stage[SYNC_STAGES-1]));
  assign bin_out  = bin_wide[CNT_W-1:0];
endmodule

// File: rtl/fll_freq_meter.sv
`timescale 1ns/1ps
module fll_freq_meter import fll_lock_pkg::*; #(
  parameter int MULT_W   = 11,
  parameter int GATE_CYC = 4,
  parameter int TOL_PCT  = 6,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MULT_W-1:0] mult_cfg,
  input  logic [CNT_W-1:0]  edge_cnt,
  output logic [MULT_W-1:0] mult_q,
  output logic              cfg_chg,
  output logic              meas_stb,
  output logic              meas_ok
);
  localparam int GATE_W = $clog2(GATE_CYC + 1);
  localparam int EXP_W  = MULT_W + GATE_W;
  localparam int PW     = ((EXP_W > CNT_W) ? EXP_W : CNT_W) + 8;

  logic [GATE_W-1:0] gate_cnt;
  logic [CNT_W-1:0]  prev_cnt;
  logic [CNT_W-1:0]  delta;
  logic              primed;
  logic              gate_last;
  logic [EXP_W-1:0]  expect_cnt;
  logic [PW-1:0]     scaled_meas, lo_bound, hi_bound;
  logic              in_band;

  assign cfg_chg    = (mult_cfg != mult_q);
  assign gate_last  = (gate_cnt == GATE_W'(GATE_CYC - 1));
  assign delta      = edge_cnt - prev_cnt;
  assign expect_cnt = EXP_W'(mult_q) * EXP_W'(GATE_CYC);
  assign scaled_meas = PW'(delta) * PW'(PCT_SCALE);
  assign lo_bound    = PW'(expect_cnt) * PW'(PCT_SCALE - TOL_PCT);
  assign hi_bound    = PW'(expect_cnt) * PW'(PCT_SCALE + TOL_PCT);
  assign in_band     = (scaled_meas >= lo_bound) && (scaled_meas <= hi_bound);

  always_ff @(posedge clk) begin
    if (rst) begin
      mult_q   <= mult_cfg;
      gate_cnt <= '0;
      prev_cnt <= '0;
      primed   <= 1'b0;
      meas_stb <= 1'b0;
      meas_ok  <= 1'b0;
    end else begin
      mult_q   <= mult_cfg;
      meas_stb <= 1'b0;
      if (cfg_chg) begin
        gate_cnt <= '0;
        primed   <= 1'b0;
      end else if (gate_last) begin
        gate_cnt <= '0;
        prev_cnt <= edge_cnt;
        primed   <= 1'b1;
        meas_stb <= primed;
        meas_ok  <= in_band;
      end else begin
        gate_cnt <= gate_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fll_lock_qual.sv
`timescale 1ns/1ps
module fll_lock_qual #(
  parameter int QUAL_GATES = 160,
  parameter bit IRQ_EN     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_chg,
  input  logic meas_stb,
  input  logic meas_ok,
  input  logic wr_en,
  input  logic wr_data,
  output logic lock,
  output logic loss_flag,
  output logic irq
);
  localparam int QUAL_W = $clog2(QUAL_GATES + 1);

  logic [QUAL_W-1:0] good_cnt, good_nxt;
  logic              lock_nxt;
  logic              loss_set, loss_clr;

  always_comb begin
    lock_nxt = lock;
    good_nxt = good_cnt;
    if (cfg_chg) begin
      lock_nxt = 1'b0;
      good_nxt = '0;
    end else if (meas_stb) begin
      if (!meas_ok) begin
        lock_nxt = 1'b0;
        good_nxt = '0;
      end else if (good_cnt >= QUAL_W'(QUAL_GATES - 1)) begin
        lock_nxt = 1'b1;
      end else begin
        good_nxt = good_cnt + 1'b1;
      end
    end
  end

  assign loss_set = lock && !lock_nxt;
  assign loss_clr = wr_en && wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock      <= 1'b0;
      good_cnt  <= '0;
      loss_flag <= 1'b0;
    end else begin
      lock      <= lock_nxt;
      good_cnt  <= good_nxt;
      loss_flag <= loss_set || (loss_flag && !loss_clr);
    end
  end

  generate
    if (IRQ_EN) begin : g_irq
      assign irq = loss_flag;
    end else begin : g_no_irq
      assign irq = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fll_lock_detect.sv
`timescale 1ns/1ps
module fll_lock_detect #(
  parameter int MULT_W     = 11,
  parameter int GATE_CYC   = 4,
  parameter int TOL_PCT    = 6,
  parameter int QUAL_GATES = 160,
  parameter int CNT_W      = 16,
  parameter bit IRQ_EN     = 1'b1
) (
  input  logic              ref_clk,
  input  logic              gen_clk,
  input  logic              rst,
  input  logic [MULT_W-1:0] mult_cfg,
  input  logic              wr_en,
  input  logic              wr_data,
  output logic              lock,
  output logic              loss_flag,
  output logic              irq
);
  logic [CNT_W-1:0]  gray_cnt;
  logic [CNT_W-1:0]  edge_cnt;
  logic [MULT_W-1:0] mult_q;
  logic              cfg_chg, meas_stb, meas_ok;

  fll_gen_counter #(.CNT_W(CNT_W)) u_gen_cnt (
    .gen_clk(gen_clk), .rst(rst), .gray_cnt(gray_cnt));

  fll_cnt_sync #(.CNT_W(CNT_W)) u_sync (
    .clk(ref_clk), .rst(rst), .gray_in(gray_cnt), .bin_out(edge_cnt));

  fll_freq_meter #(.MULT_W(MULT_W), .GATE_CYC(GATE_CYC), .TOL_PCT(TOL_PCT),
                   .CNT_W(CNT_W)) u_meter (
    .clk(ref_clk), .rst(rst), .mult_cfg(mult_cfg), .edge_cnt(edge_cnt),
    .mult_q(mult_q), .cfg_chg(cfg_chg), .meas_stb(meas_stb), .meas_ok(meas_ok));

  fll_lock_qual #(.QUAL_GATES(QUAL_GATES), .IRQ_EN(IRQ_EN)) u_qual (
    .clk(ref_clk), .rst(rst), .cfg_chg(cfg_chg), .meas_stb(meas_stb),
    .meas_ok(meas_ok), .wr_en(wr_en), .wr_data(wr_data),
    .lock(lock), .loss_flag(loss_flag), .irq(irq));
endmodule

// File: rtl/fll_lock_checker.sv
`timescale 1ns/1ps
module fll_lock_checker #(
  parameter int MULT_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [MULT_W-1:0] mult_cfg,
  input logic [MULT_W-1:0] mult_q,
  input logic              meas_stb,
  input logic              wr_en,
  input logic              wr_data,
  input logic              lock,
  input logic              loss_flag
);
  AST_LOCK_RISE_AT_GATE: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(meas_stb)); // R3
  AST_CFG_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (mult_cfg != mult_q) |=> !lock); // R7
  AST_LOSS_NEEDS_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(loss_flag) |-> $fell(lock)); // R4
  AST_FALL_SETS_LOSS: assert property (@(posedge clk) disable iff (rst)
    $fell(lock) |-> loss_flag); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data) |=> (!loss_flag || $fell(lock))); // R5
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (loss_flag && !(wr_en && wr_data)) |=> loss_flag); // R5
endmodule

bind fll_lock_detect fll_lock_checker #(.MULT_W(MULT_W)) u_chk (
  .clk(ref_clk), .rst(rst), .mult_cfg(mult_cfg), .mult_q(mult_q),
  .meas_stb(meas_stb), .wr_en(wr_en), .wr_data(wr_data),
  .lock(lock), .loss_flag(loss_flag));

// File: tb/test_fll_lock_detect.sv
`timescale 1ns/1ps
module test_fll_lock_detect;
  localparam int MULT_W = 11;
  localparam int GATE   = 40;
  localparam int QUAL   = 8;

  logic ref_clk = 1'b0;
  logic gen_clk = 1'b0;
  logic rst = 1'b1;
  logic [MULT_W-1:0] mult_cfg = 11'd3;
  logic wr_en = 1'b0;
  logic wr_data = 1'b0;
  logic lock, loss_flag, irq;
  real  gen_half = 0.75;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2 ref_clk = ~ref_clk;
  always #(gen_half) gen_clk = ~gen_clk;

  fll_lock_detect #(.MULT_W(MULT_W), .GATE_CYC(GATE), .TOL_PCT(6),
                    .QUAL_GATES(QUAL), .CNT_W(10), .IRQ_EN(1'b1)) i_fll_lock_detect (
    .ref_clk(ref_clk), .gen_clk(gen_clk), .rst(rst), .mult_cfg(mult_cfg),
    .wr_en(wr_en), .wr_data(wr_data), .lock(lock), .loss_flag(loss_flag), .irq(irq));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic write_bit(input logic d);
    wr_en = 1'b1; wr_data = d;
    cyc(1);
    wr_en = 1'b0; wr_data = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(20);
    chk("R9 lock in reset", lock, 1'b0);
    chk("R9 loss in reset", loss_flag, 1'b0);
    rst = 1'b0;
    cyc(1);
    chk("R9 irq after reset", irq, 1'b0);
  endtask

  task automatic t_no_loss_before_lock;
    cyc(10 * GATE); // 11% low count, mult 3
    chk("R2 low count keeps lock off", lock, 1'b0);
    chk("R4 no loss before first lock", loss_flag, 1'b0);
  endtask

  task automatic t_qualify;
    gen_half = 0.667; // 120 edges per gate
    cyc((QUAL - 1) * GATE);
    chk("R3 lock not early", lock, 1'b0);
    cyc(3 * GATE);
    chk("R3 lock after window", lock, 1'b1);
    chk("R1 nominal no loss", loss_flag, 1'b0);
  endtask

  task automatic t_collision;
    mult_cfg = 11'd4; gen_half = 0.5;
    wr_en = 1'b1; wr_data = 1'b1;
    cyc(1);
    wr_en = 1'b0; wr_data = 1'b0;
    chk("R7 cfg change drops lock", lock, 1'b0);
    chk("R6 set wins over clear", loss_flag, 1'b1);
    chk("R8 irq follows loss", irq, 1'b1);
  endtask

  task automatic t_clear;
    write_bit(1'b0);
    chk("R5 write 0 ignored", loss_flag, 1'b1);
    write_bit(1'b1);
    chk("R5 write 1 clears", loss_flag, 1'b0);
    chk("R8 irq cleared", irq, 1'b0);
  endtask

  task automatic t_relock;
    cyc((QUAL - 1) * GATE - 4);
    chk("R7 qualification restarted", lock, 1'b0);
    cyc(4 * GATE);
    chk("R7 relock at new mult", lock, 1'b1);
  endtask

  task automatic t_band_edges;
    gen_half = 0.525; // 4.8% low
    cyc(5 * GATE);
    chk("R1 4.8% low holds lock", lock, 1'b1);
    gen_half = 0.48;  // 4.2% high
    cyc(5 * GATE);
    chk("R1 4.2% high holds lock", lock, 1'b1);
    chk("R1 no loss inside band", loss_flag, 1'b0);
    gen_half = 0.5;
    cyc(2 * GATE);
  endtask

  task automatic t_glitch;
    gen_half = 0.46; // 8.7% high
    cyc(3 * GATE);
    chk("R2 high count drops lock", lock, 1'b0);
    chk("R4 loss set on drop", loss_flag, 1'b1);
    gen_half = 0.5;
    cyc((QUAL - 1) * GATE);
    chk("R2 qualification restarted", lock, 1'b0);
    cyc(3 * GATE);
    chk("R3 relock after glitch", lock, 1'b1);
    chk("R4 loss stays sticky", loss_flag, 1'b1);
  endtask

  initial begin
    t_reset;
    t_no_loss_before_lock;
    t_qualify;
    t_collision;
    t_clear;
    t_relock;
    t_band_edges;
    t_glitch;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule